// File: doc/BRIEF.md
# I2C Byte Command Sequencer

This block sits between a command register and a bit-level I2C engine. It takes one command word and turns it into the series of single-bit operations that make up an I2C byte transfer. Those operations are an optional START, eight data bits, one acknowledge bit and an optional STOP, always issued in that order. On a write it shifts the transmit byte out MSB first and captures the slave's acknowledge. On a read it shifts the incoming bits into a byte and then drives the acknowledge value held in the command word.

The bit engine sees one command at a time on `bit_cmd_o` and holds it until it returns a one-cycle `bit_ack_i`. The sequencer then moves to the next bit. When the whole command has finished, `done_o` pulses once. If the bit engine reports lost arbitration, the sequence is cut short: the sequencer returns to idle and `done_o` still pulses. A START issued while the bus is already owned gives a repeated start, because no STOP is ever inserted unless the command asks for one.

Top module: `i2c_byte_seq`

## Requirements
- R1: While `rst_ni` is low and after reset, `bit_cmd_o` is 0 (no operation), `done_o` is 0, `rx_byte_o` is 0 and `rx_ack_o` is 0.
- R2: The command word is sampled only on a cycle with `cmd_valid_i` high while the block is idle. Bit 7 requests START, bit 6 requests STOP, bit 5 requests a byte read, bit 4 requests a byte write, and bit 3 is the acknowledge value sent after a read (0 = ACK, 1 = NACK). Without such a cycle `bit_cmd_o` stays 0.
- R3: The bit commands on `bit_cmd_o` use the codes 1 = START, 2 = STOP, 3 = WRITE and 4 = READ. Within one command they appear in the order START, data bits, acknowledge bit, STOP, and any part the command does not request is skipped.
- R4: A byte write issues eight WRITE commands with `bit_wr_o` carrying `tx_byte_i` MSB first. It then issues one READ command, and the bit returned on `bit_rd_i` for it is stored in `rx_ack_o` (1 = NACK).
- R5: A byte read issues exactly eight READ commands, followed by one WRITE command whose `bit_wr_o` equals command bit 3.
- R6: Read bits are assembled MSB first. `rx_byte_o` changes only when the eighth read bit completes and holds its previous value during the transfer.
- R7: `done_o` is a single-cycle pulse in the cycle after the last bit handshake of the command. While it is high, `bit_cmd_o` is 0.
- R8: When `arb_lost_i` is high while a bit command is outstanding, the sequencer returns to idle in the next cycle with `done_o` high, and it issues no further bit commands.
- R9: A `cmd_valid_i` pulse arriving while a command is in progress is ignored, and an outstanding bit command holds until its handshake.
- R10: A command with START set begins with a START bit even when the previous command left the bus owned (no STOP), so the result is a repeated start.
- R11: A command word with none of the START, STOP, READ and WRITE bits set issues no bit command and pulses `done_o` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command word valid, taken only when idle |
| cmd_i | input | 5 | Command bits [7:3]: START, STOP, READ, WRITE, ack value |
| tx_byte_i | input | DW | Byte to transmit, sampled with the command |
| bit_cmd_o | output | 3 | Bit command to the bit engine (0 none, 1 START, 2 STOP, 3 WRITE, 4 READ) |
| bit_wr_o | output | 1 | Bit value for a WRITE bit command |
| bit_ack_i | input | 1 | One-cycle pulse from the bit engine: current bit command finished |
| bit_rd_i | input | 1 | Bit sampled by the bit engine, valid with `bit_ack_i` |
| arb_lost_i | input | 1 | Arbitration lost, reported by the bit engine |
| rx_byte_o | output | DW | Last received byte |
| rx_ack_o | output | 1 | Acknowledge captured after the last write (1 = NACK) |
| done_o | output | 1 | One-cycle pulse when the command has finished |

## Verification
The bench runs a bit-engine model that logs every bit command and compares the whole log against the expected sequence. A design that swapped the order of the parts, dropped the STOP, inserted a STOP before a repeated start, or shifted the data LSB first would produce a different log. During a read, `rx_byte_o` is sampled after the fourth bit; a design that updated the byte on every bit would show a partial value there. A new command is pushed in during a write to catch a design that accepts work while busy, and arbitration loss is raised in the middle of a byte to catch a design that keeps issuing bits or never signals done. An empty command word checks that the sequencer does not hang or emit stray bits.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

  typedef enum logic [2:0] {
    BC_NOP   = 3'd0,
    BC_START = 3'd1,
    BC_STOP  = 3'd2,
    BC_WRITE = 3'd3,
    BC_READ  = 3'd4
  } bcmd_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_ACK,
    S_STOP
  } seq_state_e;

  typedef struct packed {
    logic start;
    logic stop;
    logic rd;
    logic wr;
    logic ackv;
  } seq_cmd_t;

endpackage

// File: rtl/i2cseq_shift.sv
module i2cseq_shift #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] data_i,
  input  logic          shift_i,
  input  logic          in_bit_i,
  output logic [DW-1:0] q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= '0;
    else if (load_i)  q_o <= data_i;
    else if (shift_i) q_o <= {q_o[DW-2:0], in_bit_i};
  end

endmodule

// File: rtl/i2cseq_cnt.sv
module i2cseq_cnt #(
  parameter int unsigned DW = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic dec_i,
  output logic last_o
);

  localparam int unsigned CW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] TOP = CW'(DW - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (load_i)                  cnt_q <= TOP;
    else if (dec_i && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == '0);

endmodule

// File: rtl/i2cseq_fsm.sv
module i2cseq_fsm
  import i2cseq_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     cmd_valid_i,
  input  seq_cmd_t cmd_i,
  input  logic     bit_ack_i,
  input  logic     arb_lost_i,
  input  logic     last_i,
  output bcmd_e    bit_cmd_o,
  output logic     accept_o,
  output logic     data_step_o,
  output logic     rd_fin_o,
  output logic     ack_cap_o,
  output logic     in_data_o,
  output logic     rd_mode_o,
  output logic     ackv_o,
  output logic     done_o
);

  seq_state_e st_q, st_n;
  seq_cmd_t   cq;
  logic       done_n;
  logic       step;

  // next phase after START (or immediately on accept)
  function automatic seq_state_e after_start(input seq_cmd_t c);
    if (c.rd || c.wr) return S_DATA;
    if (c.stop)       return S_STOP;
    return S_IDLE;
  endfunction

  assign accept_o = (st_q == S_IDLE) && cmd_valid_i;
  assign step     = bit_ack_i && !arb_lost_i;

  always_comb begin
    st_n   = st_q;
    done_n = 1'b0;
    unique case (st_q)
      S_IDLE: if (cmd_valid_i) begin
        st_n   = cmd_i.start ? S_START : after_start(cmd_i);
        done_n = (st_n == S_IDLE);
      end
      S_START: if (step) begin
        st_n   = after_start(cq);
        done_n = (st_n == S_IDLE);
      end
      S_DATA: if (step && last_i) st_n = S_ACK;
      S_ACK: if (step) begin
        st_n   = cq.stop ? S_STOP : S_IDLE;
        done_n = !cq.stop;
      end
      S_STOP: if (step) begin
        st_n   = S_IDLE;
        done_n = 1'b1;
      end
      default: st_n = S_IDLE;
    endcase
    if (st_q != S_IDLE && arb_lost_i) begin
      st_n   = S_IDLE;
      done_n = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      cq     <= '0;
      done_o <= 1'b0;
    end else begin
      st_q   <= st_n;
      done_o <= done_n;
      if (accept_o) cq <= cmd_i;
    end
  end

  always_comb begin
    unique case (st_q)
      S_START: bit_cmd_o = BC_START;
      S_DATA:  bit_cmd_o = cq.rd ? BC_READ : BC_WRITE;
      S_ACK:   bit_cmd_o = cq.rd ? BC_WRITE : BC_READ;
      S_STOP:  bit_cmd_o = BC_STOP;
      default: bit_cmd_o = BC_NOP;
    endcase
  end

  // read takes precedence when both data directions are requested
  assign in_data_o   = (st_q == S_DATA);
  assign data_step_o = in_data_o && step;
  assign rd_fin_o    = data_step_o && last_i && cq.rd;
  assign ack_cap_o   = (st_q == S_ACK) && step && !cq.rd;
  assign rd_mode_o   = cq.rd;
  assign ackv_o      = cq.ackv;

endmodule

// File: rtl/i2c_byte_seq.sv
module i2c_byte_seq
  import i2cseq_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  input  logic [7:3]    cmd_i,
  input  logic [DW-1:0] tx_byte_i,
  output logic [2:0]    bit_cmd_o,
  output logic          bit_wr_o,
  input  logic          bit_ack_i,
  input  logic          bit_rd_i,
  input  logic          arb_lost_i,
  output logic [DW-1:0] rx_byte_o,
  output logic          rx_ack_o,
  output logic          done_o
);

  seq_cmd_t      cmd_s;
  bcmd_e         bc;
  logic          accept, data_step, rd_fin, ack_cap;
  logic          in_data, rd_mode, ackv, last;
  logic [DW-1:0] sh_q;

  assign cmd_s = '{start: cmd_i[7], stop: cmd_i[6], rd: cmd_i[5],
                   wr: cmd_i[4], ackv: cmd_i[3]};

  i2cseq_fsm i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cmd_i       (cmd_s),
    .bit_ack_i   (bit_ack_i),
    .arb_lost_i  (arb_lost_i),
    .last_i      (last),
    .bit_cmd_o   (bc),
    .accept_o    (accept),
    .data_step_o (data_step),
    .rd_fin_o    (rd_fin),
    .ack_cap_o   (ack_cap),
    .in_data_o   (in_data),
    .rd_mode_o   (rd_mode),
    .ackv_o      (ackv),
    .done_o      (done_o)
  );

  i2cseq_shift #(.DW(DW)) i_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (accept),
    .data_i   (tx_byte_i),
    .shift_i  (data_step),
    .in_bit_i (bit_rd_i),
    .q_o      (sh_q)
  );

  i2cseq_cnt #(.DW(DW)) i_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .dec_i  (data_step),
    .last_o (last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_byte_o <= '0;
      rx_ack_o  <= 1'b0;
    end else begin
      if (rd_fin)  rx_byte_o <= {sh_q[DW-2:0], bit_rd_i};
      if (ack_cap) rx_ack_o  <= bit_rd_i;
    end
  end

  assign bit_cmd_o = bc;
  // released (1) whenever the bit value is not meaningful
  assign bit_wr_o  = in_data ? (rd_mode ? 1'b1 : sh_q[DW-1])
                             : (rd_mode ? ackv : 1'b1);

endmodule

// File: rtl/i2c_byte_seq_chk.sv
module i2c_byte_seq_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cmd_valid_i,
  input logic [2:0]    bit_cmd_o,
  input logic          bit_ack_i,
  input logic          arb_lost_i,
  input logic [DW-1:0] rx_byte_o,
  input logic          done_o
);

  assert_done_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> bit_cmd_o == 3'd0);

  assert_arb_abort_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arb_lost_i && bit_cmd_o != 3'd0) |=> (done_o && bit_cmd_o == 3'd0));

  assert_rx_update_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_byte_o != $past(rx_byte_o)) |-> $past(bit_ack_i && bit_cmd_o == 3'd4));

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_cmd_o != 3'd0 && !bit_ack_i && !arb_lost_i) |=> $stable(bit_cmd_o));

  assert_no_spont_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_cmd_o == 3'd0 && !cmd_valid_i) |=> bit_cmd_o == 3'd0);

endmodule

bind i2c_byte_seq i2c_byte_seq_chk #(.DW(DW)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .bit_cmd_o   (bit_cmd_o),
  .bit_ack_i   (bit_ack_i),
  .arb_lost_i  (arb_lost_i),
  .rx_byte_o   (rx_byte_o),
  .done_o      (done_o)
);

// File: tb/test_i2c_byte_seq.sv
`timescale 1ns/1ps
module test_i2c_byte_seq;

  localparam int DW  = 8;
  localparam int LAT = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [7:3]    cmd = '0;
  logic [DW-1:0] tx = '0;
  logic [2:0]    bit_cmd;
  logic          bit_wr;
  logic          bit_ack = 1'b0;
  logic          bit_rd = 1'b0;
  logic          arb = 1'b0;
  logic [DW-1:0] rx_byte;
  logic          rx_ack;
  logic          done;

  int total = 0;
  int bad   = 0;

  logic [3:0] lg [0:63];
  int         lg_n = 0;
  logic [3:0] ex [0:63];
  int         ex_n = 0;
  logic [7:0] rd_src = '0;
  logic       slv_ack = 1'b0;
  logic       rd_mode = 1'b0;

  always #2.5 clk = ~clk;

  i2c_byte_seq #(.DW(DW)) i_i2c_byte_seq (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cmd_valid_i (cmd_valid),
    .cmd_i       (cmd),
    .tx_byte_i   (tx),
    .bit_cmd_o   (bit_cmd),
    .bit_wr_o    (bit_wr),
    .bit_ack_i   (bit_ack),
    .bit_rd_i    (bit_rd),
    .arb_lost_i  (arb),
    .rx_byte_o   (rx_byte),
    .rx_ack_o    (rx_ack),
    .done_o      (done)
  );

  // bit engine model: each bit command takes LAT cycles, then one ack pulse
  initial begin
    int cnt;
    cnt = 0;
    forever begin
      @(negedge clk);
      if (bit_ack) begin
        bit_ack = 1'b0;
        cnt = 0;
      end else if (!rst_n || bit_cmd == 3'd0) begin
        cnt = 0;
      end else begin
        cnt++;
        if (cnt == LAT) begin
          if (lg_n < 64) lg[lg_n] = {bit_cmd, (bit_cmd == 3'd3) ? bit_wr : 1'b0};
          lg_n++;
          if (bit_cmd == 3'd4) begin
            if (rd_mode) begin
              bit_rd = rd_src[7];
              rd_src = {rd_src[6:0], 1'b0};
            end else begin
              bit_rd = slv_ack;
            end
          end
          bit_ack = 1'b1;
          cnt = 0;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [2:0] c, input logic w);
    ex[ex_n] = {c, w};
    ex_n++;
  endtask

  task automatic push_wbyte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) push(3'd3, b[i]);
  endtask

  task automatic push_rbyte();
    for (int i = 0; i < 8; i++) push(3'd4, 1'b0);
  endtask

  task automatic cmp_log(input string req);
    chk(lg_n == ex_n, req, "bit command count", lg_n, ex_n);
    for (int i = 0; i < ex_n && i < lg_n; i++)
      chk(lg[i] == ex[i], req, $sformatf("bit command %0d", i), lg[i], ex[i]);
  endtask

  task automatic issue(input logic [7:3] c, input logic [7:0] b);
    lg_n = 0;
    ex_n = 0;
    @(negedge clk); #1;
    cmd_valid = 1'b1;
    cmd = c;
    tx = b;
    @(negedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n;
    n = 0;
    while (!done && n < 3000) begin
      @(negedge clk); #1;
      n++;
    end
    chk(done, req, "done pulse seen", done, 1);
    chk(bit_cmd == 3'd0, "R7", "no bit command with done", bit_cmd, 0);
    @(negedge clk); #1;
    chk(!done, "R7", "done lasts one cycle", done, 0);
  endtask

  task automatic wait_log(input int k);
    int n;
    n = 0;
    while (lg_n < k && n < 3000) begin
      @(negedge clk); #1;
      n++;
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(bit_cmd == 3'd0, "R1", "bit_cmd in reset", bit_cmd, 0);
    chk(!done, "R1", "done in reset", done, 0);
    chk(rx_byte == '0, "R1", "rx_byte in reset", rx_byte, 0);
    chk(!rx_ack, "R1", "rx_ack in reset", rx_ack, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(bit_cmd == 3'd0, "R2", "idle without command", bit_cmd, 0);
  endtask

  task automatic t_start_write();
    rd_mode = 1'b0; slv_ack = 1'b0;
    issue(5'b10010, 8'hA5);
    wait_done("R3");
    push(3'd1, 1'b0); push_wbyte(8'hA5); push(3'd4, 1'b0);
    cmp_log("R3");
    chk(rx_ack == 1'b0, "R4", "slave ACK captured", rx_ack, 0);
  endtask

  task automatic t_write_nack();
    rd_mode = 1'b0; slv_ack = 1'b1;
    issue(5'b00010, 8'h3C);
    wait_done("R4");
    push_wbyte(8'h3C); push(3'd4, 1'b0);
    cmp_log("R4");
    chk(rx_ack == 1'b1, "R4", "slave NACK captured", rx_ack, 1);
  endtask

  task automatic t_write_stop();
    rd_mode = 1'b0; slv_ack = 1'b0;
    issue(5'b01010, 8'h5A);
    wait_done("R3");
    push_wbyte(8'h5A); push(3'd4, 1'b0); push(3'd2, 1'b0);
    cmp_log("R3");
    chk(rx_ack == 1'b0, "R4", "ACK after write with stop", rx_ack, 0);
  endtask

  task automatic t_read(input logic [7:3] c, input logic [7:0] val, input logic nack,
                        input logic with_stop);
    logic [7:0] prev;
    prev = rx_byte;
    rd_mode = 1'b1;
    rd_src = val;
    issue(c, 8'h00);
    wait_log(4);
    chk(rx_byte == prev, "R6", "rx_byte held mid-read", rx_byte, prev);
    wait_done("R5");
    push_rbyte(); push(3'd3, nack);
    if (with_stop) push(3'd2, 1'b0);
    cmp_log("R5");
    chk(rx_byte == val, "R6", "received byte", rx_byte, val);
    rd_mode = 1'b0;
  endtask

  task automatic t_stop_only();
    issue(5'b01000, 8'h00);
    wait_done("R3");
    push(3'd2, 1'b0);
    cmp_log("R3");
  endtask

  task automatic t_repeated_start();
    rd_mode = 1'b0; slv_ack = 1'b0;
    issue(5'b10010, 8'h20);
    wait_done("R10");
    push(3'd1, 1'b0); push_wbyte(8'h20); push(3'd4, 1'b0);
    cmp_log("R10");
    issue(5'b10010, 8'hA1);
    wait_done("R10");
    push(3'd1, 1'b0); push_wbyte(8'hA1); push(3'd4, 1'b0);
    cmp_log("R10");
  endtask

  task automatic t_empty();
    int seen;
    issue(5'b00000, 8'hFF);
    chk(done, "R11", "done for empty command", done, 1);
    seen = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); #1;
      if (done) seen++;
    end
    chk(lg_n == 0, "R11", "no bit commands", lg_n, 0);
    chk(seen == 0, "R11", "no further done", seen, 0);
  endtask

  task automatic t_busy();
    int seen;
    int n0;
    rd_mode = 1'b0; slv_ack = 1'b0;
    issue(5'b00010, 8'hC6);
    wait_log(3);
    cmd_valid = 1'b1;
    cmd = 5'b01000;
    @(negedge clk); #1;
    cmd_valid = 1'b0;
    wait_done("R9");
    push_wbyte(8'hC6); push(3'd4, 1'b0);
    cmp_log("R9");
    n0 = lg_n;
    seen = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk); #1;
      if (done) seen++;
    end
    chk(lg_n == n0, "R9", "no stray STOP afterwards", lg_n, n0);
    chk(seen == 0, "R9", "no extra done", seen, 0);
  endtask

  task automatic t_arb();
    int seen;
    int n0;
    rd_mode = 1'b0; slv_ack = 1'b0;
    issue(5'b11010, 8'hFF);
    wait_log(3);
    arb = 1'b1;
    @(negedge clk); #1;
    arb = 1'b0;
    chk(done, "R8", "done after arbitration loss", done, 1);
    chk(bit_cmd == 3'd0, "R8", "idle after arbitration loss", bit_cmd, 0);
    n0 = lg_n;
    seen = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk); #1;
      if (done) seen++;
      if (bit_cmd != 3'd0) seen++;
    end
    chk(lg_n == n0, "R8", "no bit commands after abort", lg_n, n0);
    chk(seen == 0, "R8", "quiet after abort", seen, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_start_write();
    t_write_nack();
    t_write_stop();
    t_read(5'b00100, 8'hC3, 1'b0, 1'b0);
    t_read(5'b01101, 8'h96, 1'b1, 1'b1);
    t_stop_only();
    t_repeated_start();
    t_empty();
    t_busy();
    t_arb();
    repeat (5) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule